// File: doc/BRIEF.md
# I2C Controller Clock Enable Generator

This block produces the clock enable that paces every synchronous element of an I2C controller. A four-stage divider counts system clocks, and a 2-bit rate field picks its divide-by-16 tap, its divide-by-4 tap, or the undivided system clock. The selected tap is retimed by a register and emitted as a single-cycle enable pulse. All logic sits in the system clock domain.

The same block also derives the controller's internal reset from the two role-enable configuration bits, one for the bus-master role and one for the bus-target role. While both bits are clear, the divider and the output are held at rest. Setting either bit releases the reset on the next clock edge. The first enable pulse appears two system clocks after the configuration change is sampled. A new rate chosen while running is applied at the next divider wrap, so the interval already in progress always completes.

Top module: `i2c_clk_enable_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `clk_en` and `blk_rst_n` are 0 after that edge.
- R2: While `mst_en` and `slv_en` are both 0, `blk_rst_n` stays 0 and `clk_en` never pulses.
- R3: `blk_rst_n` becomes 1 after the first rising edge that samples `mst_en` or `slv_en` high.
- R4: The first `clk_en` pulse follows the second rising edge that samples an enable bit high, one cycle after `blk_rst_n` rises.
- R5: With `rate_sel` = 2'b00, `clk_en` is a one-cycle pulse repeated every 16 system clocks.
- R6: With `rate_sel` = 2'b01, `clk_en` is a one-cycle pulse repeated every 4 system clocks.
- R7: With `rate_sel` = 2'b10, `clk_en` is high on every cycle.
- R8: `rate_sel` = 2'b11 is reserved and paces `clk_en` exactly as 2'b00 does.
- R9: A change of `rate_sel` while running does not alter the interval in progress. The new rate governs the interval that starts at the next divider wrap, so no interval is ever cut short.
- R10: The rising edge that samples both enable bits low drives `blk_rst_n` and `clk_en` to 0. A later enable restarts with the R4 latency.
- R11: Moving the enable from one bit to the other in the same cycle, without both being low, leaves the pulse train uninterrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_en | input | 1 | Bus-master role enable bit |
| slv_en | input | 1 | Bus-target role enable bit |
| rate_sel | input | 2 | Rate field: 00 /16, 01 /4, 10 /1, 11 reserved (/16) |
| blk_rst_n | output | 1 | Controller internal reset, active low |
| clk_en | output | 1 | One-cycle clock enable pulse |

## Verification
A wrong divider count or a stale latched rate shows at `clk_en` as a pulse arriving early or late. This is visible at the first pulse after the fault, at most sixteen cycles later. A reset-control fault shows at once, on the edge after the enable bits change: `blk_rst_n` takes the wrong level, or the first pulse does not land exactly two edges after the write. The bench predicts the cycle of every pulse from the requirements. It therefore reports a missing pulse, a pulse at the wrong time, and a pulse that should not exist, including any pulse while the block is idle.

// File: rtl/i2c_ckgen_pkg.sv
// Package: shared encodings for the I2C clock enable generator.
// Assumes: rate field is 2 bits wide; reserved code falls back to the slowest tap.
package i2c_ckgen_pkg;

    typedef enum logic [1:0] {
        RATE_DIV16 = 2'b00,
        RATE_DIV4  = 2'b01,
        RATE_SYS   = 2'b10,
        RATE_RSVD  = 2'b11
    } rate_e;

endpackage

// File: rtl/ckgen_rst_ctl.sv
// Module: ckgen_rst_ctl
// Combines the two role-enable bits and registers the result as the
// controller's internal run flag (inverse of the block reset).
// Assumes: enable bits are already synchronous to clk.
module ckgen_rst_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_en,
    input  logic slv_en,
    output logic cfg_en,
    output logic blk_run
);

    // Either role enable keeps the block alive.
    always_comb begin
        cfg_en = mst_en | slv_en;
    end

    // Synchronous release and re-assertion of the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_run <= 1'b0;
        end else begin
            blk_run <= cfg_en;
        end
    end

endmodule

// File: rtl/ckgen_divider.sv
// Module: ckgen_divider
// Synchronous counter standing in for the divider chain. The active tap is
// latched from the rate field while idle and at every wrap, so a new rate
// never truncates the interval in progress. tick is high on count zero.
// Assumes: LO_TAP < DIV_STAGES; run is the registered block-run flag.
module ckgen_divider
    import i2c_ckgen_pkg::*;
#(
    parameter int DIV_STAGES = 4,
    parameter int LO_TAP     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       tick
);

    localparam int CW = DIV_STAGES;
    localparam int SW = $clog2(DIV_STAGES + 1);
    localparam logic [SW-1:0] SH_HI = SW'(DIV_STAGES);
    localparam logic [SW-1:0] SH_LO = SW'(LO_TAP);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [SW-1:0] act_shift;
    logic [SW-1:0] req_shift;
    logic          wrap;

    // Decode the requested rate into a tap position (log2 of the period).
    always_comb begin
        case (rate_e'(rate_sel))
            RATE_DIV4: req_shift = SH_LO;
            RATE_SYS:  req_shift = '0;
            default:   req_shift = SH_HI;
        endcase
    end

    // Terminal count of the active tap: low act_shift bits set.
    always_comb begin
        last = '0;
        for (int i = 0; i < CW; i++) begin
            if (i < int'(act_shift)) begin
                last[i] = 1'b1;
            end
        end
    end

    // Wrap and tick detection.
    always_comb begin
        wrap = (cnt == last);
        tick = run && (cnt == '0);
    end

    // Counter and tap latch; both held at rest while the block is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt       <= '0;
            act_shift <= req_shift;
        end else if (wrap) begin
            cnt       <= '0;
            act_shift <= req_shift;
        end else begin
            cnt       <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ckgen_resync.sv
// Module: ckgen_resync
// Retimes the divider tick through one system-clock register to form the
// glitch-free clock enable; the gate drops it on the edge that disables.
// Assumes: tick and gate are synchronous to clk.
module ckgen_resync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic gate,
    output logic clk_en
);

    // Output register: one pulse per tick while the enable bits hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en <= 1'b0;
        end else begin
            clk_en <= tick & gate;
        end
    end

endmodule

// File: rtl/i2c_clk_enable_gen.sv
// Module: i2c_clk_enable_gen
// Top of the I2C clock enable generator: block reset control, divider with
// rate latch, and output retiming register.
// Assumes: single clock domain; configuration inputs synchronous to clk.
module i2c_clk_enable_gen #(
    parameter int DIV_STAGES = 4,
    parameter int LO_TAP     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mst_en,
    input  logic       slv_en,
    input  logic [1:0] rate_sel,
    output logic       blk_rst_n,
    output logic       clk_en
);

    logic cfg_en;
    logic blk_run;
    logic tick;

    ckgen_rst_ctl u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .mst_en  (mst_en),
        .slv_en  (slv_en),
        .cfg_en  (cfg_en),
        .blk_run (blk_run)
    );

    ckgen_divider #(
        .DIV_STAGES (DIV_STAGES),
        .LO_TAP     (LO_TAP)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (blk_run),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    ckgen_resync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .gate   (cfg_en),
        .clk_en (clk_en)
    );

    // Block reset is the inverse sense of the run flag.
    always_comb begin
        blk_rst_n = blk_run;
    end

endmodule

// File: rtl/i2c_clk_enable_gen_chk.sv
// Module: i2c_clk_enable_gen_chk
// Property checker bound to the top. Measures the spacing between enable
// pulses with a saturating counter instead of deep $past windows.
module i2c_clk_enable_gen_chk #(
    parameter int DIV_STAGES = 4,
    parameter int LO_TAP     = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mst_en,
    input logic       slv_en,
    input logic [1:0] rate_sel,
    input logic       blk_rst_n,
    input logic       clk_en
);

    localparam int GMAX = (1 << DIV_STAGES) + 1;
    localparam int GW   = $clog2(GMAX + 1);
    localparam logic [GW-1:0] G_HI = GW'(1 << DIV_STAGES);
    localparam logic [GW-1:0] G_LO = GW'(1 << LO_TAP);

    logic [GW-1:0] gap;
    logic          have_prev;
    logic          any_en;

    // Role enables combined for the properties.
    always_comb begin
        any_en = mst_en | slv_en;
    end

    // Cycles since the previous pulse within the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || !blk_rst_n) begin
            gap       <= '0;
            have_prev <= 1'b0;
        end else if (clk_en) begin
            gap       <= GW'(1);
            have_prev <= 1'b1;
        end else if (gap != GW'(GMAX)) begin
            gap       <= gap + 1'b1;
        end
    end

    // R2: both enables low keeps the block in reset.
    p_idle_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !blk_rst_n);

    // R2: no pulse while the block reset is asserted.
    p_no_pulse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_rst_n |-> !clk_en);

    // R3: block reset releases only after an enable was sampled.
    p_release_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_rst_n) |-> $past(any_en));

    // R4: first pulse one cycle after release when still enabled.
    p_first_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(blk_rst_n) && any_en) |=> clk_en);

    // R9: every interval is one of the legal tap periods, never shortened.
    p_gap_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && have_prev) |-> (gap == GW'(1) || gap == G_LO || gap == G_HI));

    // R10: dropping both enables clears the output on the next edge.
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !clk_en);

    // R1: rate field is never X while running (sanity on the driven config).
    p_rate_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rst_n |-> !$isunknown(rate_sel));

endmodule

bind i2c_clk_enable_gen i2c_clk_enable_gen_chk #(
    .DIV_STAGES (DIV_STAGES),
    .LO_TAP     (LO_TAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_en    (mst_en),
    .slv_en    (slv_en),
    .rate_sel  (rate_sel),
    .blk_rst_n (blk_rst_n),
    .clk_en    (clk_en)
);

// File: tb/tb_i2c_clk_enable_gen.sv
// Scoreboard bench: drivers queue the cycle numbers where pulses are due,
// a negedge monitor pops and compares every observed pulse.
module tb_i2c_clk_enable_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mst_en;
    logic       slv_en;
    logic [1:0] rate_sel;
    logic       blk_rst_n;
    logic       clk_en;

    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string cur_req = "R2";

    i2c_clk_enable_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mst_en    (mst_en),
        .slv_en    (slv_en),
        .rate_sel  (rate_sel),
        .blk_rst_n (blk_rst_n),
        .clk_en    (clk_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Cycle index: number of rising edges seen so far.
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: every pulse must match the next expected cycle.
    always @(negedge clk) begin
        if (clk_en === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected pulse (R2)"}, cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, {cur_req, " pulse cycle"}, cyc, e);
            end
        end
    end

    // Push n expected pulses starting at first, spaced by period.
    task automatic push_train(input int first, input int period, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(first + k * period);
    endtask

    task automatic wait_cycle(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // Enable at the current negedge; returns the cycle of the first pulse.
    task automatic enable(input logic m, input logic s, input logic [1:0] r, output int first);
        mst_en   = m;
        slv_en   = s;
        rate_sel = r;
        first    = cyc + 2;
        @(negedge clk);
        check(blk_rst_n === 1'b1, "R3 blk_rst_n after enable", int'(blk_rst_n), 1);
        check(clk_en === 1'b0, "R4 no pulse one edge after enable", int'(clk_en), 0);
    endtask

    // Disable at the current negedge and confirm the idle state.
    task automatic disable_all();
        mst_en = 1'b0;
        slv_en = 1'b0;
        @(negedge clk);
        check(blk_rst_n === 1'b0, "R10 blk_rst_n after disable", int'(blk_rst_n), 0);
        check(clk_en === 1'b0, "R10 clk_en after disable", int'(clk_en), 0);
        cur_req = "R2";
        repeat (12) @(negedge clk);
        check(blk_rst_n === 1'b0, "R2 block held in reset while idle", int'(blk_rst_n), 0);
    endtask

    initial begin
        int f;
        rst_n    = 1'b0;
        mst_en   = 1'b0;
        slv_en   = 1'b0;
        rate_sel = 2'b00;
        repeat (3) @(negedge clk);
        check(clk_en === 1'b0, "R1 clk_en in reset", int'(clk_en), 0);
        check(blk_rst_n === 1'b0, "R1 blk_rst_n in reset", int'(blk_rst_n), 0);
        mst_en = 1'b1;
        @(negedge clk);
        check(blk_rst_n === 1'b0, "R1 reset overrides enable", int'(blk_rst_n), 0);
        mst_en = 1'b0;
        rst_n  = 1'b1;
        repeat (20) @(negedge clk);
        check(blk_rst_n === 1'b0, "R2 idle after reset", int'(blk_rst_n), 0);

        // R5 and R4: divide-by-16 via the master bit.
        cur_req = "R5";
        enable(1'b1, 1'b0, 2'b00, f);
        push_train(f, 16, 4);
        wait_cycle(f + 48);
        disable_all();

        // R6: divide-by-4 via the target bit.
        cur_req = "R6";
        enable(1'b0, 1'b1, 2'b01, f);
        push_train(f, 4, 5);
        wait_cycle(f + 16);
        disable_all();

        // R7: undivided system clock.
        cur_req = "R7";
        enable(1'b1, 1'b0, 2'b10, f);
        push_train(f, 1, 10);
        wait_cycle(f + 9);
        disable_all();

        // R8: reserved code paces like divide-by-16.
        cur_req = "R8";
        enable(1'b0, 1'b1, 2'b11, f);
        push_train(f, 16, 3);
        wait_cycle(f + 32);
        disable_all();

        // R9: /16 -> /4 mid-interval, then /4 -> /16.
        cur_req = "R9";
        enable(1'b1, 1'b0, 2'b00, f);
        exp_q.push_back(f);
        push_train(f + 16, 4, 4);
        exp_q.push_back(f + 44);
        wait_cycle(f + 3);
        rate_sel = 2'b01;
        wait_cycle(f + 24);
        rate_sel = 2'b00;
        wait_cycle(f + 44);
        disable_all();

        // R11: hand the enable from master to target bit in one cycle.
        cur_req = "R11";
        enable(1'b1, 1'b0, 2'b01, f);
        push_train(f, 4, 4);
        wait_cycle(f + 2);
        mst_en = 1'b0;
        slv_en = 1'b1;
        @(negedge clk);
        check(blk_rst_n === 1'b1, "R11 block stays running", int'(blk_rst_n), 1);
        wait_cycle(f + 12);
        disable_all();

        // R10: restart after disable shows the R4 latency again.
        cur_req = "R10";
        enable(1'b0, 1'b1, 2'b00, f);
        push_train(f, 16, 2);
        wait_cycle(f + 16);
        disable_all();

        check(exp_q.size() == 0, "R4 all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired (R2)", cyc, 20000);
        finish_run();
    end

endmodule